// File: doc/BRIEF.md
# Stream Ready-Latency Adapter

This block joins a streaming producer that uses a same-cycle handshake (a beat moves when valid and ready are both high) to a consumer whose ready signal is announced a fixed number of cycles, `LATENCY`, ahead of the cycle in which it actually takes data. Beats accepted from the producer wait in a small skid FIFO. A history of the consumer's ready signal tells the adapter which future cycles are granted, and a beat is presented downstream only in such a cycle.

Channel and error sideband fields travel with each data word and keep their pairing. Every signal driven toward the consumer comes straight from a flip-flop. The producer is held off only when the skid FIFO has no free entry. The FIFO depth must be at least `LATENCY + 1`, and the default is `LATENCY + 2`.

Top module: `rla_adapter`

## Requirements
- R1: A beat is taken from the producer at a clock edge exactly when `inValid` and `inReady` are both high in the cycle before that edge, and each such beat is taken once.
- R2: `outValid` is high only in a granted cycle, which is a cycle t where `outReady` was high in cycle t-LATENCY. LATENCY may be 1 to 4, and the default is 4.
- R3: `outValid` is high in cycle t exactly when t is a granted cycle and at least one beat was waiting in the FIFO in cycle t-1. A beat taken at the edge that ends cycle t-1 does not count as waiting in cycle t-1.
- R4: Beats leave in the order they were taken, with none lost or repeated, and each beat's channel and error fields stay with its data.
- R5: `inReady` is high exactly when fewer than FIFO_DEPTH beats are waiting. A beat stops waiting at the edge that places it on the outputs.
- R6: If the consumer grants nothing while the producer offers beats continuously, exactly FIFO_DEPTH beats are taken and `inReady` then stays low.
- R7: `outData`, `outChannel` and `outError` keep their previous values in every cycle where `outValid` is low.
- R8: A synchronous reset empties the FIFO, clears the ready history and zeroes the outputs. After reset, `outValid` is low, `inReady` is high, and no beat from before the reset ever appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Producer offers a beat |
| inReady | output | 1 | Adapter can take a beat this cycle |
| inData | input | DATA_W | Producer data |
| inChannel | input | CHAN_W | Producer channel number |
| inError | input | ERR_W | Producer error flags |
| outReady | input | 1 | Consumer grant, effective LATENCY cycles later |
| outValid | output | 1 | Beat presented in a granted cycle |
| outData | output | DATA_W | Presented data, registered |
| outChannel | output | CHAN_W | Presented channel, registered |
| outError | output | ERR_W | Presented error flags, registered |

## Verification
The assertions check every cycle that a presented beat falls in a granted cycle and that `inReady` matches the occupancy derived from the two handshakes. They also check that the FIFO is never overfilled, that no beat appears without a beat having been taken, that the payload is held while idle, and that reset leaves the outputs idle. Only the bench scenarios can show that beats come out in order with their sideband intact, that a granted cycle is never wasted while data waits, and that a reset in the middle of traffic discards stored beats. They also show that a consumer withholding grants causes exactly FIFO_DEPTH beats to be taken. These scenarios use both patterned and pseudo-random grant sequences at latency 4.

// File: rtl/rla_pkg.sv
package rla_pkg;

  // Strobes from control to datapath, one clock edge's worth of action.
  typedef struct packed {
    logic push;  // store the producer beat at this edge
    logic pop;   // move the FIFO head onto the outputs at this edge
  } rlaStrobes_t;

endpackage

// File: rtl/rla_ctrl.sv
module rla_ctrl
  import rla_pkg::*;
#(
  parameter int LATENCY    = 4,
  parameter int FIFO_DEPTH = 6
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  input  logic        outReady,
  output logic        inReady,
  output rlaStrobes_t strobes
);

  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

  logic [CNT_W-1:0] fillCnt;
  logic             grantNext;  // next cycle is a granted cycle

  // The grant for the next cycle is outReady delayed by LATENCY-1 cycles.
  generate
    if (LATENCY == 1) begin : g_direct
      assign grantNext = outReady;
    end else begin : g_hist
      logic [LATENCY-2:0] readyHist;
      logic [LATENCY-1:0] tapVec;

      assign tapVec = {readyHist, outReady};

      always_ff @(posedge clk) begin
        if (rst) begin
          readyHist <= '0;
        end else begin
          readyHist <= tapVec[LATENCY-2:0];
        end
      end

      assign grantNext = tapVec[LATENCY-1];
    end
  endgenerate

  assign inReady = (fillCnt < CNT_W'(FIFO_DEPTH));

  always_comb begin
    strobes.push = inValid & inReady;
    strobes.pop  = grantNext & (fillCnt != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fillCnt <= '0;
    end else begin
      case ({strobes.push, strobes.pop})
        2'b10:   fillCnt <= fillCnt + 1'b1;
        2'b01:   fillCnt <= fillCnt - 1'b1;
        default: fillCnt <= fillCnt;
      endcase
    end
  end

endmodule

// File: rtl/rla_datapath.sv
module rla_datapath
  import rla_pkg::*;
#(
  parameter int PAY_W      = 19,
  parameter int FIFO_DEPTH = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  rlaStrobes_t      strobes,
  input  logic [PAY_W-1:0] inPayload,
  output logic             outValid,
  output logic [PAY_W-1:0] outPayload
);

  localparam int PTR_W = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;

  logic [PAY_W-1:0] skidMem [FIFO_DEPTH];
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;

  function automatic logic [PTR_W-1:0] bumpPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(FIFO_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (strobes.push) begin
      skidMem[wrPtr] <= inPayload;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr      <= '0;
      rdPtr      <= '0;
      outValid   <= 1'b0;
      outPayload <= '0;
    end else begin
      outValid <= strobes.pop;
      if (strobes.push) begin
        wrPtr <= bumpPtr(wrPtr);
      end
      if (strobes.pop) begin
        rdPtr      <= bumpPtr(rdPtr);
        outPayload <= skidMem[rdPtr];
      end
    end
  end

endmodule

// File: rtl/rla_adapter.sv
module rla_adapter
  import rla_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int CHAN_W     = 2,
  parameter int ERR_W      = 1,
  parameter int LATENCY    = 4,
  parameter int FIFO_DEPTH = LATENCY + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  output logic              inReady,
  input  logic [DATA_W-1:0] inData,
  input  logic [CHAN_W-1:0] inChannel,
  input  logic [ERR_W-1:0]  inError,
  input  logic              outReady,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic [CHAN_W-1:0] outChannel,
  output logic [ERR_W-1:0]  outError
);

  localparam int PAY_W = DATA_W + CHAN_W + ERR_W;

  rlaStrobes_t      strobes;
  logic [PAY_W-1:0] inPayload;
  logic [PAY_W-1:0] outPayload;

  assign inPayload = {inData, inChannel, inError};
  assign {outData, outChannel, outError} = outPayload;

  rla_ctrl #(
    .LATENCY   (LATENCY),
    .FIFO_DEPTH(FIFO_DEPTH)
  ) ctrl_i (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .outReady(outReady),
    .inReady (inReady),
    .strobes (strobes)
  );

  rla_datapath #(
    .PAY_W     (PAY_W),
    .FIFO_DEPTH(FIFO_DEPTH)
  ) dp_i (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .inPayload (inPayload),
    .outValid  (outValid),
    .outPayload(outPayload)
  );

endmodule

// File: rtl/rla_adapter_chk.sv
module rla_adapter_chk #(
  parameter int LATENCY    = 4,
  parameter int FIFO_DEPTH = 6,
  parameter int PAY_W      = 19
) (
  input logic             clk,
  input logic             rst,
  input logic             inValid,
  input logic             inReady,
  input logic             outReady,
  input logic             outValid,
  input logic [PAY_W-1:0] outPayload
);

  logic [LATENCY-1:0] seenReady;  // seenReady[k]: outReady k+1 cycles ago
  logic [15:0]        heldCnt;    // taken minus presented in earlier cycles
  logic [15:0]        waiting;

  always_ff @(posedge clk) begin
    if (rst) begin
      seenReady <= '0;
      heldCnt   <= '0;
    end else begin
      seenReady[0] <= outReady;
      for (int k = 1; k < LATENCY; k++) begin
        seenReady[k] <= seenReady[k-1];
      end
      heldCnt <= heldCnt + 16'(inValid && inReady) - 16'(outValid);
    end
  end

  assign waiting = heldCnt - 16'(outValid);

  // R2
  a_r2_valid_only_when_granted: assert property (@(posedge clk) disable iff (rst)
    outValid |-> seenReady[LATENCY-1]);

  // R4
  a_r4_no_phantom_beat: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (heldCnt != 16'd0));

  // R5
  a_r5_ready_tracks_space: assert property (@(posedge clk) disable iff (rst)
    inReady == (waiting < 16'(FIFO_DEPTH)));

  // R6
  a_r6_never_overfilled: assert property (@(posedge clk) disable iff (rst)
    waiting <= 16'(FIFO_DEPTH));

  // R7
  a_r7_payload_held: assert property (@(posedge clk) disable iff (rst)
    !outValid |-> $stable(outPayload));

  // R8
  a_r8_reset_idle: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!outValid && inReady));

endmodule

bind rla_adapter rla_adapter_chk #(
  .LATENCY   (LATENCY),
  .FIFO_DEPTH(FIFO_DEPTH),
  .PAY_W     (DATA_W + CHAN_W + ERR_W)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .inValid   (inValid),
  .inReady   (inReady),
  .outReady  (outReady),
  .outValid  (outValid),
  .outPayload({outData, outChannel, outError})
);

// File: tb/rla_adapter_tb_top.sv
module rla_adapter_tb_top;

  localparam int DATA_W = 16;
  localparam int CHAN_W = 2;
  localparam int ERR_W  = 1;
  localparam int LAT    = 4;
  localparam int DEPTH  = LAT + 2;
  localparam int PAY_W  = DATA_W + CHAN_W + ERR_W;

  // {outReady mask[31:16], inValid mask[15:0]}, bit c used in cycle c.
  localparam logic [31:0] PATTERNS [12] = '{
    32'hFFFF_FFFF, 32'h0000_FFFF, 32'hFFFF_0000, 32'hAAAA_FFFF,
    32'h5555_3333, 32'hF0F0_FFFF, 32'h0F0F_AAAA, 32'h8001_FFFF,
    32'hFFFF_8421, 32'h00FF_FF00, 32'hCCCC_CCCC, 32'h1248_7777
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              inValid = 1'b0;
  logic              inReady;
  logic [DATA_W-1:0] inData = '0;
  logic [CHAN_W-1:0] inChannel = '0;
  logic [ERR_W-1:0]  inError = '0;
  logic              outReady = 1'b0;
  logic              outValid;
  logic [DATA_W-1:0] outData;
  logic [CHAN_W-1:0] outChannel;
  logic [ERR_W-1:0]  outError;

  always #2.5 clk = ~clk;

  rla_adapter #(
    .DATA_W(DATA_W), .CHAN_W(CHAN_W), .ERR_W(ERR_W),
    .LATENCY(LAT), .FIFO_DEPTH(DEPTH)
  ) dut_i (
    .clk(clk), .rst(rst),
    .inValid(inValid), .inReady(inReady),
    .inData(inData), .inChannel(inChannel), .inError(inError),
    .outReady(outReady), .outValid(outValid),
    .outData(outData), .outChannel(outChannel), .outError(outError)
  );

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  // Reference model state
  logic [PAY_W-1:0] expQ [$];
  logic [7:0]       rh;        // rh[k]: outReady k+1 cycles ago
  int               waitPrev;
  bit               accPrev;
  logic [PAY_W-1:0] lastPay;
  logic [15:0]      seq;
  int               acceptedCnt;
  int               emittedCnt;

  function automatic logic [PAY_W-1:0] payOf(input logic [15:0] s);
    return {s, s[1:0] ^ s[5:4], s[7]};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic modelClear();
    expQ.delete();
    rh = '0;
    waitPrev = 0;
    accPrev = 1'b0;
    lastPay = '0;
  endtask

  // One cycle: check outputs at the negedge, then drive this cycle's inputs.
  task automatic step(input logic rdy, input logic vld);
    logic [PAY_W-1:0] gotPay;
    bit grant;
    bit expValid;
    int waitNow;
    @(negedge clk);
    gotPay   = {outData, outChannel, outError};
    grant    = rh[LAT-1];
    expValid = grant && (waitPrev > 0);
    waitNow  = waitPrev + int'(accPrev) - int'(expValid);
    if (outValid && !grant)
      check(1'b0, "R2", "valid outside granted cycle", outValid, 0);
    else
      check(outValid == expValid, "R3", "outValid", outValid, expValid);
    check(inReady == (waitNow < DEPTH), "R5", "inReady", inReady, waitNow < DEPTH);
    if (outValid) begin
      emittedCnt++;
      if (expQ.size() == 0) begin
        check(1'b0, "R4", "beat with empty model", gotPay, 0);
      end else begin
        check(gotPay == expQ[0], "R4", "payload order", gotPay, expQ[0]);
        void'(expQ.pop_front());
      end
      lastPay = gotPay;
    end else begin
      check(gotPay == lastPay, "R7", "payload held", gotPay, lastPay);
    end
    // drive cycle inputs
    outReady  = rdy;
    inValid   = vld;
    {inData, inChannel, inError} = payOf(seq);
    accPrev   = vld && inReady;  // R1: taken only when both high
    if (accPrev) begin
      expQ.push_back(payOf(seq));
      seq = seq + 16'd1;
      acceptedCnt++;
    end
    rh = {rh[6:0], rdy};
    waitPrev = waitNow;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    inValid = 1'b0;
    outReady = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    modelClear();
    // R8: state right after reset release
    check(!outValid, "R8", "outValid after reset", outValid, 0);
    check(inReady, "R8", "inReady after reset", inReady, 1);
    check({outData, outChannel, outError} == '0, "R8", "payload after reset",
          {outData, outChannel, outError}, 0);
  endtask

  initial begin
    seq = 16'd1;
    acceptedCnt = 0;
    emittedCnt = 0;
    modelClear();
    doReset();

    // R6: consumer grants nothing, producer pushes continuously
    acceptedCnt = 0;
    for (int i = 0; i < DEPTH + 6; i++) step(1'b0, 1'b1);
    check(acceptedCnt == DEPTH, "R6", "beats taken while blocked", acceptedCnt, DEPTH);
    check(!inReady, "R6", "inReady while full", inReady, 0);
    // drain
    emittedCnt = 0;
    for (int i = 0; i < DEPTH + LAT + 4; i++) step(1'b1, 1'b0);
    check(emittedCnt == DEPTH, "R4", "beats drained", emittedCnt, DEPTH);

    // patterned traffic
    for (int e = 0; e < 12; e++)
      for (int r = 0; r < 3; r++)
        for (int c = 0; c < 16; c++)
          step(PATTERNS[e][16+c], PATTERNS[e][c]);

    // pseudo-random grants and offers
    begin
      logic [15:0] lfsr = 16'hACE1;
      for (int i = 0; i < 1500; i++) begin
        step(lfsr[0] | lfsr[5], lfsr[3] | lfsr[9]);
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      end
    end
    for (int i = 0; i < DEPTH + LAT + 4; i++) step(1'b1, 1'b0);
    check(expQ.size() == 0, "R4", "beats left after drain", expQ.size(), 0);

    // R8: reset mid-stream discards stored beats
    for (int i = 0; i < DEPTH; i++) step(1'b0, 1'b1);
    doReset();
    emittedCnt = 0;
    for (int i = 0; i < LAT + 10; i++) step(1'b1, 1'b0);
    check(emittedCnt == 0, "R8", "beats after mid-stream reset", emittedCnt, 0);

    // short burst after reset, full grant
    for (int i = 0; i < 20; i++) step(1'b1, 1'b1);
    for (int i = 0; i < DEPTH + LAT + 4; i++) step(1'b1, 1'b0);
    check(expQ.size() == 0, "R1", "all taken beats delivered", expQ.size(), 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule